// File: doc/BRIEF.md
# Operator Lookup-Table Engine

This block computes an operator's result by reading a precomputed table instead of doing arithmetic. A request carries an operator code, a first operand, and a second operand. The second operand is either a register value or an immediate constant of the same width. The request also carries an offset. A small per-operator table supplies a base address. The read address is the base, plus the offset, plus a table index built by joining the two operands. Because of the offset, several tables can live in one memory.

A 3-bit mode field sets how wide the operands are treated. In whole mode the full operands form one index and the full table word is returned. The halves and quarters modes cut both operands into two or four narrow blocks. Each block builds its own index and returns its own narrow result field. Field 0 sits in the least significant bits.

A parameter picks the variant:
- The sequential variant has one table bank and reads the blocks one per cycle.
- The parallel variant has one bank per block and reads all blocks in the same cycle.

A separate write port loads table words into a mask-selected set of banks, and another port loads the base table.

Top module: `lut_op_engine`

## Requirements
- R1: After reset, `busy` and `done` are low and `result` is zero.
- R2: Any mode value other than 2 and 4 is whole mode. The index is {a, b} with a in the upper bits. The read address is (base[op] + off + index) mod 2^AW, and `result` is the full word read.
- R3: Mode 2 splits both operands into halves. Block i uses the index {a half i, b half i}, with half 0 being the low bits. Block i's address is formed as in R2. The low DW/2 bits of block i's word go to result field i, and field 0 is the least significant.
- R4: Mode 4 does the same as R3 with quarters: four blocks, each index {a quarter i, b quarter i}, and fields of DW/4 bits.
- R5: When `req_use_imm` is 1, `req_imm` replaces `req_b` as the second operand. An immediate of zero gives a one-operand function of a.
- R6: `done` rises on clock edge N+1 after the edge that accepts a request. N is the block count (1, 2 or 4) in the sequential variant and 1 in the parallel variant.
- R7: `done` is a one-cycle pulse. `busy` falls on the edge that raises `done`, and `result` holds its value until the next request is accepted.
- R8: A request presented while `busy` is high is ignored and does not alter the lookup in progress.
- R9: A table write stores `tw_data` at `tw_addr` in bank j when `tw_en` and `tw_mask[j]` are both 1. The sequential variant has only bank 0, so only mask bit 0 is used.
- R10: A read that meets a write to the same bank address on the same edge returns the newly written word.
- R11: `base_we` loads `base_val` as the base of operator `base_op`, and later lookups use that base.
- R12: In the parallel variant, block i is read from bank i. In the sequential variant every block reads bank 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Lookup request |
| req_op | input | OPC_W | Operator code |
| req_mode | input | 3 | Split mode: 2 gives halves, 4 gives quarters, any other value gives whole |
| req_use_imm | input | 1 | Use the immediate as the second operand |
| req_a | input | OPW | First operand |
| req_b | input | OPW | Second operand (register form) |
| req_imm | input | OPW | Constant second operand |
| req_off | input | AW | Table offset added to the address |
| base_we | input | 1 | Base table write enable |
| base_op | input | OPC_W | Operator whose base is written |
| base_val | input | AW | New base address |
| tw_en | input | 1 | Table write enable |
| tw_mask | input | 4 | Bank select for table writes |
| tw_addr | input | AW | Table write address |
| tw_data | input | DW | Table write data |
| busy | output | 1 | Lookup in progress |
| done | output | 1 | One-cycle pulse when the result is complete |
| result | output | DW | Assembled lookup result |

## Verification
On every cycle, the assertions check four things:
- `done` is a single-cycle pulse that coincides with the fall of `busy`;
- the latched operands stay stable while busy;
- the edge count from acceptance to `done` matches the block count;
- a same-address write is forwarded to the read port, and a base write lands in the base table.

Only the bench's scenarios can show the rest:
- that each mode forms the right addresses and packs the fields in the right order;
- that the immediate really replaces the second operand;
- that a masked write leaves the other banks untouched;
- that the two variants read distinct banks.

The bench covers these with full operand sweeps in every mode, against a table model it keeps itself.

// File: rtl/lut_pkg.sv
package lut_pkg;

   localparam int NBLK_MAX = 4;

   localparam logic [2:0] MODE_HALF    = 3'd2;
   localparam logic [2:0] MODE_QUARTER = 3'd4;

   // block count selected by a mode value; every other value is whole-word
   function automatic logic [2:0] nblk_of(input logic [2:0] mode);
      case (mode)
         MODE_HALF:    return 3'd2;
         MODE_QUARTER: return 3'd4;
         default:      return 3'd1;
      endcase
   endfunction

endpackage

// File: rtl/lut_base_table.sv
module lut_base_table #(
   parameter int NOPS  = 4,
   parameter int OPC_W = 2,
   parameter int AW    = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [OPC_W-1:0] wop,
   input  logic [AW-1:0]    wval,
   input  logic [OPC_W-1:0] rop,
   output logic [AW-1:0]    rbase
);

   logic [AW-1:0] base_q [NOPS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < NOPS; k++) base_q[k] <= '0;
      end else if (we) begin
         base_q[wop] <= wval;
      end
   end

   assign rbase = base_q[rop];

   // R11
   base_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> base_q[$past(wop)] == $past(wval));

endmodule

// File: rtl/lut_addr_gen.sv
module lut_addr_gen
   import lut_pkg::*;
#(
   parameter int OPW = 4,
   parameter int AW  = 9
) (
   input  logic [AW-1:0]                 base,
   input  logic [AW-1:0]                 off,
   input  logic [OPW-1:0]                opa,
   input  logic [OPW-1:0]                opb,
   input  logic [2:0]                    nblk,
   output logic [NBLK_MAX-1:0][AW-1:0]   addr
);

   localparam int HW = OPW / 2;
   localparam int QW = OPW / 4;

   logic [AW-1:0] root;
   assign root = base + off;

   for (genvar i = 0; i < NBLK_MAX; i++) begin : g_blk
      localparam int HI = (i < 2) ? i : 0;
      logic [AW-1:0] ix_w, ix_h, ix_q, ix;

      assign ix_w = (i == 0) ? AW'({opa, opb}) : '0;
      assign ix_h = (i < 2)  ? AW'({opa[HI*HW +: HW], opb[HI*HW +: HW]}) : '0;
      assign ix_q = AW'({opa[i*QW +: QW], opb[i*QW +: QW]});

      always_comb begin
         case (nblk)
            3'd2:    ix = ix_h;
            3'd4:    ix = ix_q;
            default: ix = ix_w;
         endcase
      end

      assign addr[i] = root + ix;
   end

endmodule

// File: rtl/lut_table_bank.sv
module lut_table_bank #(
   parameter int AW = 9,
   parameter int DW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);

   localparam int DEPTH = 1 << AW;

   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
      if (we && (waddr == raddr)) rdata <= wdata;
      else                        rdata <= mem[raddr];
   end

   // R10
   raw_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (we && waddr == raddr) |=> rdata == $past(wdata));

endmodule

// File: rtl/lut_op_engine.sv
module lut_op_engine
   import lut_pkg::*;
#(
   parameter int OPW      = 4,
   parameter int DW       = 16,
   parameter int AW       = 9,
   parameter int OPC_W    = 2,
   parameter int PARALLEL = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic [OPC_W-1:0] req_op,
   input  logic [2:0]       req_mode,
   input  logic             req_use_imm,
   input  logic [OPW-1:0]   req_a,
   input  logic [OPW-1:0]   req_b,
   input  logic [OPW-1:0]   req_imm,
   input  logic [AW-1:0]    req_off,
   input  logic             base_we,
   input  logic [OPC_W-1:0] base_op,
   input  logic [AW-1:0]    base_val,
   input  logic             tw_en,
   input  logic [3:0]       tw_mask,
   input  logic [AW-1:0]    tw_addr,
   input  logic [DW-1:0]    tw_data,
   output logic             busy,
   output logic             done,
   output logic [DW-1:0]    result
);

   localparam int NOPS  = 1 << OPC_W;
   localparam int NBANK = (PARALLEL != 0) ? NBLK_MAX : 1;
   localparam int F2    = DW / 2;
   localparam int F4    = DW / 4;

   if (OPW % 4 != 0) begin : g_bad_opw
      $error("OPW must be a multiple of 4");
   end
   if (DW % 4 != 0) begin : g_bad_dw
      $error("DW must be a multiple of 4");
   end
   if (AW <= 2*OPW) begin : g_bad_aw
      $error("AW must exceed twice OPW");
   end
   if (PARALLEL != 0 && PARALLEL != 1) begin : g_bad_par
      $error("PARALLEL must be 0 or 1");
   end

   // latched request
   logic [OPC_W-1:0] op_q;
   logic [OPW-1:0]   a_q, b_q;
   logic [AW-1:0]    off_q;
   logic [2:0]       nblk_q;

   // control
   logic             busy_q, issuing_q, cap_v_q, done_q;
   logic [1:0]       issue_cnt, cap_idx;
   logic [DW-1:0]    acc_q, acc_next;
   logic [3:0]       lat_q;

   logic [2:0]       steps;
   logic [1:0]       last_idx;
   assign steps    = (PARALLEL != 0) ? 3'd1 : nblk_q;
   assign last_idx = 2'(steps - 3'd1);

   logic [AW-1:0]                 base_rd;
   logic [NBLK_MAX-1:0][AW-1:0]   addrs;
   logic [DW-1:0]                 rdv [NBLK_MAX];

   lut_base_table #(.NOPS(NOPS), .OPC_W(OPC_W), .AW(AW)) u_base (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (base_we),
      .wop   (base_op),
      .wval  (base_val),
      .rop   (op_q),
      .rbase (base_rd)
   );

   lut_addr_gen #(.OPW(OPW), .AW(AW)) u_adg (
      .base (base_rd),
      .off  (off_q),
      .opa  (a_q),
      .opb  (b_q),
      .nblk (nblk_q),
      .addr (addrs)
   );

   for (genvar j = 0; j < NBLK_MAX; j++) begin : g_bank
      if (j < NBANK) begin : g_on
         logic [AW-1:0] ra;
         assign ra = (PARALLEL != 0) ? addrs[j] : addrs[issue_cnt];
         lut_table_bank #(.AW(AW), .DW(DW)) u_bank (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (tw_en & tw_mask[j]),
            .waddr (tw_addr),
            .wdata (tw_data),
            .raddr (ra),
            .rdata (rdv[j])
         );
      end else begin : g_off
         assign rdv[j] = '0;
      end
   end

   if (PARALLEL == 0) begin : g_seq_mask
      logic unused_mask_hi;
      assign unused_mask_hi = ^tw_mask[3:1];
   end

   // place captured words into result fields
   always_comb begin
      acc_next = acc_q;
      case (nblk_q)
         3'd2: begin
            for (int i = 0; i < 2; i++) begin
               if (PARALLEL != 0 || cap_idx == 2'(i))
                  acc_next[i*F2 +: F2] = rdv[(PARALLEL != 0) ? i : 0][F2-1:0];
            end
         end
         3'd4: begin
            for (int i = 0; i < 4; i++) begin
               if (PARALLEL != 0 || cap_idx == 2'(i))
                  acc_next[i*F4 +: F4] = rdv[(PARALLEL != 0) ? i : 0][F4-1:0];
            end
         end
         default: acc_next = rdv[0];
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         op_q      <= '0;
         a_q       <= '0;
         b_q       <= '0;
         off_q     <= '0;
         nblk_q    <= 3'd1;
         busy_q    <= 1'b0;
         issuing_q <= 1'b0;
         cap_v_q   <= 1'b0;
         issue_cnt <= '0;
         cap_idx   <= '0;
         acc_q     <= '0;
         done_q    <= 1'b0;
         lat_q     <= '0;
      end else begin
         done_q <= 1'b0;
         if (!busy_q) begin
            if (req_valid) begin
               op_q      <= req_op;
               a_q       <= req_a;
               b_q       <= req_use_imm ? req_imm : req_b;
               off_q     <= req_off;
               nblk_q    <= nblk_of(req_mode);
               busy_q    <= 1'b1;
               issuing_q <= 1'b1;
               cap_v_q   <= 1'b0;
               issue_cnt <= '0;
               acc_q     <= '0;
               lat_q     <= '0;
            end
         end else begin
            lat_q   <= lat_q + 4'd1;
            cap_v_q <= issuing_q;
            cap_idx <= issue_cnt;
            if (issuing_q) begin
               if (issue_cnt == last_idx) issuing_q <= 1'b0;
               else                       issue_cnt <= issue_cnt + 2'd1;
            end
            if (cap_v_q) begin
               acc_q <= acc_next;
               if (cap_idx == last_idx) begin
                  done_q <= 1'b1;
                  busy_q <= 1'b0;
               end
            end
         end
      end
   end

   assign busy   = busy_q;
   assign done   = done_q;
   assign result = acc_q;

   // R7
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !done_q);

   // R7
   busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_q) |-> done_q);

   // R8
   hold_opnd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && $past(busy_q)) |-> ($stable(a_q) && $stable(b_q) && $stable(op_q)));

   // R6
   latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |-> lat_q == ((PARALLEL != 0) ? 4'd2 : (4'(nblk_q) + 4'd1)));

   // R6
   issue_rng_chk: assert property (@(posedge clk) disable iff (!rst_n)
      issuing_q |-> issue_cnt <= last_idx);

endmodule

// File: tb/sim_lut_op_engine.sv
module sim_lut_op_engine;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic        rst_n;
   logic        req_valid, req_use_imm, base_we, tw_en;
   logic [1:0]  req_op, base_op;
   logic [2:0]  req_mode;
   logic [3:0]  req_a, req_b, req_imm, tw_mask;
   logic [8:0]  req_off, base_val, tw_addr;
   logic [15:0] tw_data;
   logic        busy0, done0, busy1, done1;
   logic [15:0] res0, res1;

   lut_op_engine #(.PARALLEL(0)) u0 (
      .clk, .rst_n, .req_valid, .req_op, .req_mode, .req_use_imm, .req_a, .req_b,
      .req_imm, .req_off, .base_we, .base_op, .base_val, .tw_en, .tw_mask,
      .tw_addr, .tw_data, .busy(busy0), .done(done0), .result(res0));

   lut_op_engine #(.PARALLEL(1)) u1 (
      .clk, .rst_n, .req_valid, .req_op, .req_mode, .req_use_imm, .req_a, .req_b,
      .req_imm, .req_off, .base_we, .base_op, .base_val, .tw_en, .tw_mask,
      .tw_addr, .tw_data, .busy(busy1), .done(done1), .result(res1));

   int errors = 0;
   int checks = 0;

   logic [15:0] mdl [4][512];
   int          base_m [4];

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, got, exp);
      end
   endtask

   function automatic logic [15:0] expect_res(input bit par, input int op, input int mode,
                                              input int a, input int b, input int off);
      int nb, bw, fw;
      logic [15:0] r;
      nb = (mode == 2) ? 2 : (mode == 4) ? 4 : 1;
      bw = 4 / nb;
      fw = 16 / nb;
      r  = '0;
      for (int i = 0; i < nb; i++) begin
         int idx, ad, d;
         if (nb == 1) idx = (a << 4) | b;
         else idx = (((a >> (i*bw)) & ((1 << bw) - 1)) << bw) | ((b >> (i*bw)) & ((1 << bw) - 1));
         ad = (base_m[op] + off + idx) % 512;
         d  = int'(mdl[par ? i : 0][ad]);
         r  = r | 16'((d & ((1 << fw) - 1)) << (i*fw));
      end
      return r;
   endfunction

   task automatic base_write(input int op, input int val);
      @(negedge clk);
      base_we = 1'b1; base_op = 2'(op); base_val = 9'(val);
      @(negedge clk);
      base_we = 1'b0;
      base_m[op] = val;
   endtask

   task automatic tab_write(input int addr, input logic [15:0] val, input logic [3:0] mask);
      @(negedge clk);
      tw_en = 1'b1; tw_addr = 9'(addr); tw_data = val; tw_mask = mask;
      @(negedge clk);
      tw_en = 1'b0;
      for (int j = 0; j < 4; j++) if (mask[j]) mdl[j][addr] = val;
   endtask

   task automatic run_req(input int op, input int mode, input int a, input int b,
                          input bit use_imm, input int imm, input int off, input bit spoil,
                          input int inj_k, input int inj_addr, input logic [15:0] inj_val,
                          input logic [3:0] inj_mask,
                          output logic [15:0] r0, output logic [15:0] r1,
                          output int l0, output int l1);
      @(negedge clk);
      req_valid = 1'b1; req_op = 2'(op); req_mode = 3'(mode); req_a = 4'(a);
      req_b = 4'(b); req_use_imm = use_imm; req_imm = 4'(imm); req_off = 9'(off);
      l0 = 0; l1 = 0; r0 = '0; r1 = '0;
      for (int k = 1; k <= 8; k++) begin
         @(negedge clk);
         if (done0 && l0 == 0) begin l0 = k; r0 = res0; end
         if (done1 && l1 == 0) begin l1 = k; r1 = res1; end
         if (k == 1) begin
            req_valid = spoil;
            if (spoil) begin req_a = 4'(~a); req_b = 4'(~b); req_op = 2'(op ^ 1); end
         end
         if (k == 2) req_valid = 1'b0;
         if (inj_k != 0 && k == inj_k) begin
            tw_en = 1'b1; tw_addr = 9'(inj_addr); tw_data = inj_val; tw_mask = inj_mask;
         end
         if (inj_k != 0 && k == inj_k + 1) tw_en = 1'b0;
      end
   endtask

   task automatic look_chk(input string tag, input int op, input int mode, input int a,
                           input int b, input bit use_imm, input int imm, input int off);
      logic [15:0] r0, r1;
      int l0, l1, nb, bb;
      nb = (mode == 2) ? 2 : (mode == 4) ? 4 : 1;
      bb = use_imm ? imm : b;
      run_req(op, mode, a, b, use_imm, imm, off, 1'b0, 0, 0, 16'h0, 4'h0, r0, r1, l0, l1);
      chk({tag, " seq"}, 32'(r0), 32'(expect_res(1'b0, op, mode, a, bb, off)));
      chk({tag, "/R12 par"}, 32'(r1), 32'(expect_res(1'b1, op, mode, a, bb, off)));
      chk("R6 seq latency", 32'(l0), 32'(nb + 2));
      chk("R6 par latency", 32'(l1), 32'd3);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual=timeout expected=finish");
      $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
   end

   initial begin
      logic [15:0] r0, r1, e0, e1;
      int l0, l1;
      rst_n = 1'b0; req_valid = 1'b0; req_use_imm = 1'b0; base_we = 1'b0; tw_en = 1'b0;
      req_op = '0; base_op = '0; req_mode = '0; req_a = '0; req_b = '0; req_imm = '0;
      tw_mask = '0; req_off = '0; base_val = '0; tw_addr = '0; tw_data = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 busy", 32'({busy0, busy1}), 32'd0);
      chk("R1 done", 32'({done0, done1}), 32'd0);
      chk("R1 result", 32'({res0, res1}), 32'd0);

      // R11 base table load
      for (int op = 0; op < 4; op++) base_write(op, op * 100 + 7);
      // R9 per-bank table contents
      for (int bk = 0; bk < 4; bk++)
         for (int ad = 0; ad < 512; ad++)
            tab_write(ad, 16'((ad * 73 + bk * 16'h1111 + 16'h05A3) & 16'hFFFF), 4'(1 << bk));

      // R2 R3 R4 full operand sweeps
      for (int op = 0; op < 4; op++)
         for (int a = 0; a < 16; a++)
            for (int b = 0; b < 16; b++) begin
               look_chk("R2 whole", op, 0, a, b, 1'b0, 0, op * 3);
               look_chk("R3 halves", op, 2, a, b, 1'b0, 0, op * 5);
               look_chk("R4 quarters", op, 4, a, b, 1'b0, 0, op * 7);
            end

      // R2 unassigned mode values fall back to whole
      look_chk("R2 mode3", 1, 3, 9, 6, 1'b0, 0, 11);
      look_chk("R2 mode7", 2, 7, 12, 3, 1'b0, 0, 200);
      look_chk("R2 mode1", 3, 1, 15, 15, 1'b0, 0, 511);

      // R5 immediate second operand, and immediate zero
      for (int a = 0; a < 16; a++) begin
         look_chk("R5 imm", 0, 4, a, 15 - a, 1'b1, a ^ 5, 40);
         look_chk("R5 single", 2, 0, a, 7, 1'b1, 0, 0);
      end

      // R11 base change takes effect, with address wrap
      base_write(1, 450);
      look_chk("R11 new base", 1, 0, 15, 15, 1'b0, 0, 100);

      // R8 request while busy is ignored
      run_req(1, 2, 5, 9, 1'b0, 0, 3, 1'b1, 0, 0, 16'h0, 4'h0, r0, r1, l0, l1);
      chk("R8 seq", 32'(r0), 32'(expect_res(1'b0, 1, 2, 5, 9, 3)));
      chk("R8 par", 32'(r1), 32'(expect_res(1'b1, 1, 2, 5, 9, 3)));

      // R9 masked write reaches bank 1 only
      tab_write(base_m[2], 16'hBEEF, 4'b0010);
      look_chk("R9 mask", 2, 4, 0, 0, 1'b0, 0, 0);
      look_chk("R9 mask whole", 2, 0, 0, 0, 1'b0, 0, 0);

      // R10 write on the edge that reads block 3 in the sequential variant
      e0 = expect_res(1'b0, 3, 4, 0, 0, 0);
      e0[15:12] = 4'hD;
      e1 = expect_res(1'b1, 3, 4, 0, 0, 0);
      run_req(3, 4, 0, 0, 1'b0, 0, 0, 1'b0, 4, base_m[3], 16'h123D, 4'b0001, r0, r1, l0, l1);
      mdl[0][base_m[3]] = 16'h123D;
      chk("R10 bypass seq", 32'(r0), 32'(e0));
      chk("R10 par before write", 32'(r1), 32'(e1));
      look_chk("R10 after write", 3, 0, 0, 0, 1'b0, 0, 0);

      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule